// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block places the strobes and the multiplexed address/data traffic of an 8-bit controller's external memory bus. It runs on the oscillator clock and divides it into machine cycles of twelve clocks: six states of two clocks each. Each machine cycle is split into two halves of six clocks. In every half, the address-latch strobe can pulse once and a code-memory read strobe can fire once. So when the bus is free, the latch strobe runs at one sixth of the oscillator rate.

The core hands over one request per machine cycle. A request is one of four kinds:
- a code read of two consecutive bytes, used for external execution and for table reads;
- a data read;
- a data write;
- nothing.

A data read or write holds the whole machine cycle. During it, the second latch pulse and both code-read pulses are skipped, and a six-clock read or write strobe is placed across the middle of the cycle. The high address byte comes either from the request or, for short-address data accesses, from the core's port latch. Read bytes are captured as the read strobe rises and handed to the core with a one-clock valid pulse.

A latch-disable control silences the latch strobe in cycles that carry no external access. The external-execution input overrides this control.

Top module: `ext_bus_seq`

## Requirements
- R1: While held in reset the phase counter is at 0 and the bus holds no access. Once reset is released the phase advances by one each clock and wraps from 11 to 0. In each half (phases 0-5 and 6-11), `ale` is high on the first two phases of the half when it is allowed.
- R2: In a code-read cycle (`req_kind` = 1), `psen_n` is low on phases 3-5 and 9-11, which gives two 3-clock pulses per machine cycle. `ale` pulses in both halves.
- R3: In a data-read cycle (`req_kind` = 2) or a data-write cycle (`req_kind` = 3), `ale` pulses only on phases 0-1 and `psen_n` stays high for all twelve phases. `rd_n` (for a read) or `wr_n` (for a write) is low on phases 3-8, which is six clocks. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.
- R4: `ad_out` carries the low address byte on the first three phases of a half, with `ad_oe` high. In a code-read cycle `ad_oe` is high only on those phases. In a data read, `ad_oe` is high only on phases 0-2. In a data write, `ad_out` carries the write byte on phases 3-9, and `ad_oe` is high on phases 0-9.
- R5: In a code-read cycle, the address used in the second half is the request address plus one, with the carry reaching the high byte. `ah_out` shows the high byte of the address for the current half. In a data cycle, `ah_out` shows the high address byte when `req_wide` = 1 and `p2_latch` when `req_wide` = 0. In cycles with no request, `ah_out` shows `p2_latch`.
- R6: `ad_in` is sampled on the last low clock of each `psen_n` pulse (phases 5 and 11) and of `rd_n` (phase 8). The sampled byte appears on `rdata` one clock later, with `rvalid` high for exactly that one clock.
- R7: With `ale_off` = 1 and `ext_exec` = 0, `ale` stays low through cycles that carry no request. It still pulses in code-read and data cycles.
- R8: With `ext_exec` = 1, `ale_off` has no effect and `ale` pulses as described in R1.
- R9: A request is taken only on the clock edge that ends phase 11, and it governs the following machine cycle. `req_ack` is high exactly when `req_valid` is high during phase 11. `busy` is high for the whole of a data machine cycle.
- R10: During reset, `psen_n`, `rd_n` and `wr_n` are high and `busy` and `rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_exec | input | 1 | Core executes from external code memory |
| ale_off | input | 1 | Latch-strobe disable control |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 none, 1 code read, 2 data read, 3 data write |
| req_wide | input | 1 | Data access uses a 16-bit address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| p2_latch | input | 8 | Core's high port latch contents |
| ad_in | input | 8 | Byte read from the multiplexed bus |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code-memory read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address / write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ah_out | output | 8 | High address byte |
| req_ack | output | 1 | Request taken on this edge |
| busy | output | 1 | Data machine cycle in progress |
| rdata | output | 8 | Captured read byte |
| rvalid | output | 1 | One-clock valid for `rdata` |

## Verification
The strobes, `ad_out`, `ad_oe`, `ah_out`, `busy` and `req_ack` are decoded from the phase and cycle-kind registers. They therefore follow the phase in the same clock. The exception is a request taken at the end of phase 11, which first shows its effect on phase 0 of the next machine cycle. `rdata` and `rvalid` lag the sampling clock by one register. The bench keeps its own phase and cycle-kind model, which it advances on each rising edge from the inputs present at that edge. It compares every output on the falling edge against values derived from that model. It changes the mode inputs only in phase 11.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int ADDR_W          = 16;
    localparam int DATA_W          = 8;
    localparam int CLKS_PER_STATE  = 2;
    localparam int STATES_PER_MC   = 6;

    localparam int PHASES          = CLKS_PER_STATE * STATES_PER_MC;
    localparam int HALF            = PHASES / 2;
    localparam int PH_W            = $clog2(PHASES);

    // strobe placement, derived from the state length
    localparam int ALE_CLKS        = CLKS_PER_STATE;
    localparam int ADDR_CLKS       = ALE_CLKS + 1;
    localparam int STROBE_START    = ADDR_CLKS;
    localparam int RW_CLKS         = HALF;
    localparam int RW_LAST         = STROBE_START + RW_CLKS - 1;
    localparam int WR_OE_END       = RW_LAST + 1;

    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_CODE = 2'd1,
        CYC_DRD  = 2'd2,
        CYC_DWR  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      wide;
        addr_t     addr;
        byte_t     wdata;
    } bus_cyc_t;

    function automatic phase_t ph_c(input int v);
        return phase_t'(v);
    endfunction

    function automatic logic is_data(input cyc_kind_e k);
        return (k == CYC_DRD) || (k == CYC_DWR);
    endfunction

    function automatic byte_t hi_byte(input addr_t a);
        return a[ADDR_W-1 -: DATA_W];
    endfunction

    function automatic byte_t lo_byte(input addr_t a);
        return a[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/ebus_phase.sv
module ebus_phase
    import ebus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t ph,
    output phase_t hpos,
    output logic   second_half,
    output logic   mc_last
);

    assign mc_last     = (ph == ph_c(PHASES - 1));
    assign second_half = (ph >= ph_c(HALF));
    assign hpos        = second_half ? (ph - ph_c(HALF)) : ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (mc_last) begin
            ph <= '0;
        end else begin
            ph <= ph + ph_c(1);
        end
    end

endmodule

// File: rtl/ebus_cyc_latch.sv
module ebus_cyc_latch
    import ebus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mc_last,
    input  logic      req_valid,
    input  cyc_kind_e req_kind,
    input  logic      req_wide,
    input  addr_t     req_addr,
    input  byte_t     req_wdata,
    output bus_cyc_t  cur,
    output logic      req_ack
);

    bus_cyc_t incoming;

    always_comb begin
        incoming.kind  = req_kind;
        incoming.wide  = req_wide;
        incoming.addr  = req_addr;
        incoming.wdata = req_wdata;
    end

    assign req_ack = req_valid & mc_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (mc_last) begin
            cur <= req_valid ? incoming : '0;
        end
    end

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
    import ebus_pkg::*;
(
    input  cyc_kind_e kind,
    input  phase_t    ph,
    input  phase_t    hpos,
    input  logic      second_half,
    input  logic      ale_off,
    input  logic      ext_exec,
    output logic      ale,
    output logic      psen_n,
    output logic      rd_n,
    output logic      wr_n,
    output logic      cap_now
);

    logic ale_slot;
    logic ale_allowed;
    logic ale_skip;
    logic psen_win;
    logic rw_win;

    always_comb begin
        ale_slot    = (hpos < ph_c(ALE_CLKS));
        ale_allowed = ext_exec | ~ale_off | (kind != CYC_IDLE);
        ale_skip    = is_data(kind) & second_half;
        ale         = ale_slot & ale_allowed & ~ale_skip;

        psen_win    = (hpos >= ph_c(STROBE_START));
        psen_n      = ~((kind == CYC_CODE) & psen_win);

        rw_win      = (ph >= ph_c(STROBE_START)) && (ph <= ph_c(RW_LAST));
        rd_n        = ~((kind == CYC_DRD) & rw_win);
        wr_n        = ~((kind == CYC_DWR) & rw_win);

        cap_now     = ((kind == CYC_CODE) && (hpos == ph_c(HALF - 1)))
                    | ((kind == CYC_DRD)  && (ph == ph_c(RW_LAST)));
    end

endmodule

// File: rtl/ebus_ad_mux.sv
module ebus_ad_mux
    import ebus_pkg::*;
(
    input  bus_cyc_t cur,
    input  phase_t   ph,
    input  phase_t   hpos,
    input  logic     second_half,
    input  byte_t    p2_latch,
    output byte_t    ad_out,
    output logic     ad_oe,
    output byte_t    ah_out
);

    addr_t fetch_addr;
    byte_t data_hi;
    logic  addr_phase;

    always_comb begin
        fetch_addr = second_half ? (cur.addr + addr_t'(1)) : cur.addr;
        data_hi    = cur.wide ? hi_byte(cur.addr) : p2_latch;
        addr_phase = (ph < ph_c(ADDR_CLKS));

        ad_out = '0;
        ad_oe  = 1'b0;
        ah_out = p2_latch;

        unique case (cur.kind)
            CYC_CODE: begin
                ad_oe  = (hpos < ph_c(ADDR_CLKS));
                ad_out = lo_byte(fetch_addr);
                ah_out = hi_byte(fetch_addr);
            end
            CYC_DRD: begin
                ad_oe  = addr_phase;
                ad_out = lo_byte(cur.addr);
                ah_out = data_hi;
            end
            CYC_DWR: begin
                ad_oe  = (ph <= ph_c(WR_OE_END));
                ad_out = addr_phase ? lo_byte(cur.addr) : cur.wdata;
                ah_out = data_hi;
            end
            default: begin
                ad_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_exec,
    input  logic        ale_off,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_wide,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic [7:0]  p2_latch,
    input  logic [7:0]  ad_in,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    output logic [7:0]  ah_out,
    output logic        req_ack,
    output logic        busy,
    output logic [7:0]  rdata,
    output logic        rvalid
);

    phase_t   ph;
    phase_t   hpos;
    logic     second_half;
    logic     mc_last;
    bus_cyc_t cur;
    logic     cap_now;

    ebus_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .ph          (ph),
        .hpos        (hpos),
        .second_half (second_half),
        .mc_last     (mc_last)
    );

    ebus_cyc_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .mc_last   (mc_last),
        .req_valid (req_valid),
        .req_kind  (cyc_kind_e'(req_kind)),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur       (cur),
        .req_ack   (req_ack)
    );

    ebus_strobe_gen u_strobe (
        .kind        (cur.kind),
        .ph          (ph),
        .hpos        (hpos),
        .second_half (second_half),
        .ale_off     (ale_off),
        .ext_exec    (ext_exec),
        .ale         (ale),
        .psen_n      (psen_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .cap_now     (cap_now)
    );

    ebus_ad_mux u_mux (
        .cur         (cur),
        .ph          (ph),
        .hpos        (hpos),
        .second_half (second_half),
        .p2_latch    (p2_latch),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .ah_out      (ah_out)
    );

    assign busy = is_data(cur.kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= cap_now;
            if (cap_now) begin
                rdata <= ad_in;
            end
        end
    end

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic busy,
    input logic rvalid,
    input logic req_ack
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~psen_n, ~rd_n, ~wr_n})); // R3

    AST_BUSY_NO_CODE: assert property (@(posedge clk) disable iff (rst)
        busy |-> psen_n); // R3

    AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale); // R1

    AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe); // R4

    AST_RD_FLOATS_BUS: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe); // R4

    AST_RD_RISE_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> rvalid); // R6

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid); // R6

    AST_ACK_ONCE: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack); // R9

endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_oe   (ad_oe),
    .busy    (busy),
    .rvalid  (rvalid),
    .req_ack (req_ack)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_exec = 1'b0;
    logic        ale_off = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  p2_latch = 8'h5A;
    logic [7:0]  ad_in = '0;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, req_ack, busy, rvalid;
    logic [7:0]  ad_out, ah_out, rdata;

    always #5 clk = ~clk;

    ext_bus_seq u0 (
        .clk(clk), .rst(rst), .ext_exec(ext_exec), .ale_off(ale_off),
        .req_valid(req_valid), .req_kind(req_kind), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .p2_latch(p2_latch),
        .ad_in(ad_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ah_out(ah_out), .req_ack(req_ack),
        .busy(busy), .rdata(rdata), .rvalid(rvalid)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the bus state
    int          bph = 0;
    int          bkind = 0;
    logic        bwide = 0;
    logic [15:0] baddr = '0;
    logic [7:0]  bwdata = '0;
    logic        x_rv = 0;
    logic [7:0]  x_rd = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (phase %0d kind %0d)", tag, act, exp, bph, bkind);
        end
    endtask

    function automatic logic [15:0] cur_addr(input bit half);
        return half ? baddr + 16'd1 : baddr;
    endfunction

    task automatic check_all();
        bit          half;
        int          hp;
        logic        e_ale, e_psen, e_rd, e_wr, e_oe, e_busy, e_ack;
        logic [7:0]  e_ad, e_ah;
        half   = (bph >= 6);
        hp     = half ? bph - 6 : bph;
        e_ale  = (hp < 2) && (ext_exec || !ale_off || bkind != 0) && !(bkind >= 2 && half);
        e_psen = !(bkind == 1 && hp >= 3);
        e_rd   = !(bkind == 2 && bph >= 3 && bph <= 8);
        e_wr   = !(bkind == 3 && bph >= 3 && bph <= 8);
        e_busy = (bkind >= 2);
        e_ack  = req_valid && (bph == 11);
        case (bkind)
            1: begin e_oe = (hp <= 2); e_ad = cur_addr(half)[7:0];
                     e_ah = cur_addr(half)[15:8]; end
            2: begin e_oe = (bph <= 2); e_ad = baddr[7:0];
                     e_ah = bwide ? baddr[15:8] : p2_latch; end
            3: begin e_oe = (bph <= 9); e_ad = (bph <= 2) ? baddr[7:0] : bwdata;
                     e_ah = bwide ? baddr[15:8] : p2_latch; end
            default: begin e_oe = 0; e_ad = 0; e_ah = p2_latch; end
        endcase
        chk(ale == e_ale, "R1,R3,R7,R8 ale", int'(ale), int'(e_ale));
        chk({psen_n, rd_n, wr_n} == {e_psen, e_rd, e_wr}, "R2,R3 strobes psen/rd/wr",
            int'({psen_n, rd_n, wr_n}), int'({e_psen, e_rd, e_wr}));
        chk(ad_oe == e_oe, "R4 ad_oe", int'(ad_oe), int'(e_oe));
        if (e_oe) chk(ad_out == e_ad, "R4,R5 ad_out", int'(ad_out), int'(e_ad));
        chk(ah_out == e_ah, "R5 ah_out", int'(ah_out), int'(e_ah));
        chk(busy == e_busy, "R9 busy", int'(busy), int'(e_busy));
        chk(req_ack == e_ack, "R9 req_ack", int'(req_ack), int'(e_ack));
        chk(rvalid == x_rv, "R6 rvalid", int'(rvalid), int'(x_rv));
        if (x_rv) chk(rdata == x_rd, "R6 rdata", int'(rdata), int'(x_rd));
    endtask

    task automatic step();
        @(negedge clk);
        if (rst) begin
            chk({psen_n, rd_n, wr_n} == 3'b111, "R10 strobes in reset", int'({psen_n, rd_n, wr_n}), 7);
            chk(busy == 1'b0 && rvalid == 1'b0, "R10 busy/rvalid in reset", int'({busy, rvalid}), 0);
        end else begin
            check_all();
        end
        @(posedge clk);
        if (rst) begin
            bph = 0; bkind = 0; x_rv = 0; x_rd = '0;
        end else begin
            if ((bkind == 1 && (bph == 5 || bph == 11)) || (bkind == 2 && bph == 8)) begin
                x_rv = 1; x_rd = ad_in;
            end else begin
                x_rv = 0;
            end
            if (bph == 11) begin
                if (req_valid) begin
                    bkind = int'(req_kind); bwide = req_wide; baddr = req_addr; bwdata = req_wdata;
                end else begin
                    bkind = 0;
                end
            end
            bph = (bph + 1) % 12;
        end
        #1;
        ad_in = 8'($urandom);
    endtask

    task automatic set_mode(input logic ex, input logic off);
        while (bph != 11) step();
        ext_exec = ex; ale_off = off;
    endtask

    task automatic request(input logic [1:0] k, input logic w, input logic [15:0] a, input logic [7:0] d);
        req_valid = 1; req_kind = k; req_wide = w; req_addr = a; req_wdata = d;
        while (bph != 11) step();
        step();
        req_valid = 0;
        repeat (12) step();
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (4) step();                 // R10
        rst = 0;
        repeat (24) step();                // R1 free-running latch strobe
        set_mode(1'b0, 1'b1);
        repeat (24) step();                // R7 no latch pulses while idle
        request(2'd1, 1'b0, 16'h0840, 8'h00);   // R7 table read still pulses, R2
        request(2'd2, 1'b1, 16'hA5C3, 8'h00);   // R3 R6 wide read
        p2_latch = 8'h3C;
        request(2'd2, 1'b0, 16'h77E1, 8'h00);   // R5 short address uses port latch
        request(2'd3, 1'b1, 16'h1234, 8'h9B);   // R4 write data
        request(2'd3, 1'b0, 16'hBEEF, 8'h61);   // R5 short write
        set_mode(1'b1, 1'b1);               // R8 override
        repeat (24) step();
        request(2'd1, 1'b0, 16'h12FF, 8'h00);   // R5 carry into high byte
        req_valid = 1; req_kind = 2'd2; req_wide = 1; req_addr = 16'h4000;
        repeat (36) step();                 // R9 back-to-back reads
        req_valid = 0;
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom_range(0, 1) == 1);
            req_kind  = 2'($urandom);
            req_wide  = 1'($urandom);
            req_addr  = 16'($urandom);
            req_wdata = 8'($urandom);
            if ($urandom_range(0, 30) == 0) p2_latch = 8'($urandom);
            if (bph == 11 && $urandom_range(0, 15) == 0) begin
                ext_exec = 1'($urandom); ale_off = 1'($urandom);
            end
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule